// File: doc/BRIEF.md
# Interrupt Entry and Stack Sequencer

This block sits beside a small 8-bit processor core. It takes over the memory bus while the core enters an interrupt or a software break, and while the core moves one byte to or from the stack. When a hardware request is taken or a break is issued, the block writes the return address and the status byte onto a stack held in memory page one. It then fetches a 16-bit entry vector and returns the new program counter, together with the updated status and stack pointer, to the core.

The core presents its program counter, status byte, stack pointer and accumulator with each request. The block samples them only in a cycle where `ready_o` is high. The block also carries out the single-byte stack operations that save and restore the accumulator and the status byte, using the same write-then-decrement and increment-then-read rules. Memory reads return their data one cycle after the read strobe.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset `ready_o` is 1, `done_o` and all write-enable outputs are 0, and the bus issues neither a read nor a write while `ready_o` is 1.
- R2: A hardware request (`irq_i`) is accepted only when status bit 2 (interrupt disable) of `sr_i` is 0. Otherwise it causes no bus access, no `done_o`, and `ready_o` stays 1.
- R3: Entry writes three bytes: return-address high byte to 0x0100+SP, low byte to 0x0100+SP-1, status to 0x0100+SP-2. `sp_o` ends at SP-3.
- R4: The pushed status byte has bit 4 (break) set, for hardware requests as well as breaks. The final `sr_o` has bit 4 and bit 2 set, and `sr_we_o` is 1 with `done_o`.
- R5: After the pushes, entry reads 0xFFFE (low byte) and then 0xFFFF (high byte). `pc_o` = {byte@0xFFFF, byte@0xFFFE} with `pc_we_o`. `done_o` is a one-cycle pulse 7 cycles after the accepting edge.
- R6: A break (`brk_i`) pushes the return address `pc_i`+1 (modulo 2^16). It is suppressed exactly like a hardware request when status bit 2 is set.
- R7: With `op_valid_i`, `op_sel_i` selects the operation: 00 push accumulator, 01 push status, 10 pull accumulator, 11 pull status. A push writes the byte to 0x0100+SP, sets `sp_o` to SP-1 and raises `done_o` 2 cycles after acceptance.
- R8: A pull reads 0x0100+SP+1 and sets `sp_o` to SP+1. The byte appears on `acc_o` with `acc_we_o` (10) or on `sr_o` with `sr_we_o` (11), with `done_o` 3 cycles after acceptance.
- R9: Stack pointer arithmetic wraps modulo 256 and every stack address stays within 0x0100 to 0x01FF.
- R10: In one accepting cycle, an enabled hardware request wins over a break, which wins over a stack operation. The requests that lose are dropped.
- R11: Requests presented while `ready_o` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Hardware interrupt request |
| brk_i | input | 1 | Software break request |
| op_valid_i | input | 1 | Stack operation request |
| op_sel_i | input | 2 | Stack operation select (00/01 push acc/status, 10/11 pull acc/status) |
| pc_i | input | 16 | Current program counter |
| sr_i | input | 8 | Current status byte |
| sp_i | input | 8 | Current stack pointer |
| acc_i | input | 8 | Current accumulator |
| ready_o | output | 1 | Idle; requests are sampled |
| mem_addr_o | output | 16 | Bus address |
| mem_we_o | output | 1 | Bus write strobe |
| mem_re_o | output | 1 | Bus read strobe |
| mem_wdata_o | output | 8 | Bus write data |
| mem_rdata_i | input | 8 | Bus read data, valid one cycle after `mem_re_o` |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | New program counter |
| pc_we_o | output | 1 | Load `pc_o` into the core |
| sr_o | output | 8 | New status byte |
| sr_we_o | output | 1 | Load `sr_o` into the core |
| sp_o | output | 8 | New stack pointer, valid with `done_o` |
| acc_o | output | 8 | Pulled accumulator byte |
| acc_we_o | output | 1 | Load `acc_o` into the core |

## Verification
Hardware entry, break entry and a stack operation can all be requested in the same idle cycle. The bench drives every such pairing in one cycle: hardware with break, break with a push, hardware with a push, and a masked hardware request with a push. It judges the outcome from the bus trace, which must show exactly the write count, addresses and return address of the winning request, and from the completion latency. A request arriving while a push is in progress is also driven, and it must leave no trace on the bus.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_HI,
    S_PUSH_LO,
    S_PUSH_SR,
    S_VEC_LO,
    S_VEC_HI,
    S_VEC_LD,
    S_OP_PUSH,
    S_OP_PULL,
    S_OP_CAP,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_PUSH_ACC = 2'b00,
    OP_PUSH_SR  = 2'b01,
    OP_PULL_ACC = 2'b10,
    OP_PULL_SR  = 2'b11
  } stk_op_e;

  typedef enum logic [1:0] {
    GR_NONE,
    GR_IRQ,
    GR_BRK,
    GR_OP
  } grant_e;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
  import irq_seq_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned IDIS_BIT = 2
) (
  input  logic          en_i,
  input  logic          irq_i,
  input  logic          brk_i,
  input  logic          op_valid_i,
  input  logic [DW-1:0] sr_i,
  output grant_e        grant_o
);

  logic masked;
  assign masked = sr_i[IDIS_BIT];

  // fixed priority: hardware, break, stack op
  always_comb begin
    grant_o = GR_NONE;
    if (en_i) begin
      if (irq_i && !masked)      grant_o = GR_IRQ;
      else if (brk_i && !masked) grant_o = GR_BRK;
      else if (op_valid_i)       grant_o = GR_OP;
    end
  end

endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] sp_inc_o
);

  logic [DW-1:0] sp_q;

  assign sp_inc_o = sp_q + DW'(1);
  assign sp_o     = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= load_val_i;
    else if (dec_i)  sp_q <= sp_q - DW'(1);
    else if (inc_i)  sp_q <= sp_inc_o;
  end

  assert_no_inc_dec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && inc_i));

  assert_wrap_dec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && sp_q == '0) |=> (sp_q == '1));

endmodule

// File: rtl/irq_seq_vec.sv
module irq_seq_vec #(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lo_en_i,
  input  logic            hi_en_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [2*DW-1:0] pc_o
);

  logic [DW-1:0]   lo_q;
  logic [2*DW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      pc_q <= '0;
    end else begin
      if (lo_en_i) lo_q <= rdata_i;
      if (hi_en_i) pc_q <= {rdata_i, lo_q};
    end
  end

  assign pc_o = pc_q;

  assert_vec_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_en_i |-> $past(lo_en_i));

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned BRK_BIT    = 4,
  parameter int unsigned IDIS_BIT   = 2,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          brk_i,
  input  logic          op_valid_i,
  input  logic [1:0]    op_sel_i,
  input  logic [15:0]   pc_i,
  input  logic [7:0]    sr_i,
  input  logic [7:0]    sp_i,
  input  logic [7:0]    acc_i,
  output logic          ready_o,
  output logic [15:0]   mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o,
  output logic [15:0]   pc_o,
  output logic          pc_we_o,
  output logic [7:0]    sr_o,
  output logic          sr_we_o,
  output logic [7:0]    sp_o,
  output logic [7:0]    acc_o,
  output logic          acc_we_o
);

  localparam int unsigned AW = 2 * DW;
  localparam logic [DW-1:0] BRK_MASK  = {{(DW-1){1'b0}}, 1'b1} << BRK_BIT;
  localparam logic [DW-1:0] IDIS_MASK = {{(DW-1){1'b0}}, 1'b1} << IDIS_BIT;

  seq_state_e    state_q, state_d;
  grant_e        grant;
  stk_op_e       op_q;
  logic          entry_q;
  logic [AW-1:0] ret_q;
  logic [DW-1:0] sr_q, acc_q;
  logic [DW-1:0] sr_res_q, acc_res_q;
  logic [DW-1:0] sp_cur, sp_inc;
  logic          sp_load, sp_dec, sp_inc_en;
  logic          vec_lo_en, vec_hi_en;

  irq_seq_arb #(.DW(DW), .IDIS_BIT(IDIS_BIT)) u_arb (
    .en_i      (state_q == S_IDLE),
    .irq_i     (irq_i),
    .brk_i     (brk_i),
    .op_valid_i(op_valid_i),
    .sr_i      (sr_i),
    .grant_o   (grant)
  );

  irq_seq_sp #(.DW(DW)) u_sp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sp_load),
    .load_val_i(sp_i),
    .dec_i     (sp_dec),
    .inc_i     (sp_inc_en),
    .sp_o      (sp_cur),
    .sp_inc_o  (sp_inc)
  );

  irq_seq_vec #(.DW(DW)) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lo_en_i(vec_lo_en),
    .hi_en_i(vec_hi_en),
    .rdata_i(mem_rdata_i),
    .pc_o   (pc_o)
  );

  assign sp_load = (grant != GR_NONE);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (grant == GR_IRQ || grant == GR_BRK) state_d = S_PUSH_HI;
        else if (grant == GR_OP)                state_d = op_sel_i[1] ? S_OP_PULL : S_OP_PUSH;
      end
      S_PUSH_HI: state_d = S_PUSH_LO;
      S_PUSH_LO: state_d = S_PUSH_SR;
      S_PUSH_SR: state_d = S_VEC_LO;
      S_VEC_LO:  state_d = S_VEC_HI;
      S_VEC_HI:  state_d = S_VEC_LD;
      S_VEC_LD:  state_d = S_DONE;
      S_OP_PUSH: state_d = S_DONE;
      S_OP_PULL: state_d = S_OP_CAP;
      S_OP_CAP:  state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  // bus drive and pointer control
  always_comb begin
    mem_addr_o  = {STACK_PAGE, sp_cur};
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_wdata_o = '0;
    sp_dec      = 1'b0;
    sp_inc_en   = 1'b0;
    vec_lo_en   = 1'b0;
    vec_hi_en   = 1'b0;
    unique case (state_q)
      S_PUSH_HI: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = ret_q[AW-1:DW];
        sp_dec      = 1'b1;
      end
      S_PUSH_LO: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = ret_q[DW-1:0];
        sp_dec      = 1'b1;
      end
      S_PUSH_SR: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = sr_q | BRK_MASK;
        sp_dec      = 1'b1;
      end
      S_VEC_LO: begin
        mem_re_o   = 1'b1;
        mem_addr_o = VEC_ADDR;
      end
      S_VEC_HI: begin
        mem_re_o   = 1'b1;
        mem_addr_o = VEC_ADDR + AW'(1);
        vec_lo_en  = 1'b1;
      end
      S_VEC_LD: vec_hi_en = 1'b1;
      S_OP_PUSH: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = (op_q == OP_PUSH_SR) ? sr_q : acc_q;
        sp_dec      = 1'b1;
      end
      S_OP_PULL: begin
        mem_re_o   = 1'b1;
        mem_addr_o = {STACK_PAGE, sp_inc};
        sp_inc_en  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= OP_PUSH_ACC;
      entry_q   <= 1'b0;
      ret_q     <= '0;
      sr_q      <= '0;
      acc_q     <= '0;
      sr_res_q  <= '0;
      acc_res_q <= '0;
    end else begin
      state_q <= state_d;
      if (sp_load) begin
        op_q    <= stk_op_e'(op_sel_i);
        entry_q <= (grant != GR_OP);
        ret_q   <= (grant == GR_BRK) ? pc_i + AW'(1) : pc_i;
        sr_q    <= sr_i;
        acc_q   <= acc_i;
      end
      if (state_q == S_VEC_LD) sr_res_q <= sr_q | BRK_MASK | IDIS_MASK;
      if (state_q == S_OP_CAP) begin
        if (op_q == OP_PULL_SR) sr_res_q  <= mem_rdata_i;
        else                    acc_res_q <= mem_rdata_i;
      end
    end
  end

  assign ready_o  = (state_q == S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign pc_we_o  = done_o && entry_q;
  assign sr_we_o  = done_o && (entry_q || op_q == OP_PULL_SR);
  assign acc_we_o = done_o && !entry_q && op_q == OP_PULL_ACC;
  assign sr_o     = sr_res_q;
  assign acc_o    = acc_res_q;
  assign sp_o     = sp_cur;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!mem_we_o && !mem_re_o));

  assert_masked_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && irq_i && sr_i[IDIS_BIT] && !brk_i && !op_valid_i) |=> ready_o);

  assert_entry_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (sr_o[BRK_BIT] && sr_o[IDIS_BIT] && sr_we_o));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  assert_load_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_o || sr_we_o || pc_we_o) |-> done_o);

  assert_stack_page_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[AW-1:DW] == STACK_PAGE));

  assert_busy_blind_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> !ready_o);

endmodule

// File: tb/irq_stack_seq_test.sv
`timescale 1ns/1ps
module irq_stack_seq_test;

  typedef struct packed {
    logic [1:0]  kind;  // 0 irq, 1 brk, 2 stack op
    logic [1:0]  op;
    logic [15:0] pc;
    logic [7:0]  sr;
    logic [7:0]  sp;
    logic [7:0]  acc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'b00, 16'h1234, 8'h00, 8'hFF, 8'h00},
    '{2'd0, 2'b00, 16'hABCD, 8'h81, 8'h01, 8'h00},
    '{2'd1, 2'b00, 16'h20FF, 8'h00, 8'h80, 8'h00},
    '{2'd1, 2'b00, 16'hFFFF, 8'h20, 8'h10, 8'h00},
    '{2'd2, 2'b00, 16'h0000, 8'h00, 8'h00, 8'h5A},
    '{2'd2, 2'b01, 16'h0000, 8'hC3, 8'h40, 8'h11},
    '{2'd2, 2'b10, 16'h0000, 8'h00, 8'hFF, 8'h00},
    '{2'd2, 2'b11, 16'h0000, 8'h00, 8'h7F, 8'h00}
  };

  localparam logic [7:0] VLO = 8'hEF;
  localparam logic [7:0] VHI = 8'hBE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0, brk = 1'b0, opv = 1'b0;
  logic [1:0]  opsel = 2'b00;
  logic [15:0] pc = '0;
  logic [7:0]  sr = '0, sp = '0, acc = '0;
  logic        ready, mem_we, mem_re, done, pc_we, sr_we, acc_we;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, mem_rdata, sr_out, sp_out, acc_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_stack_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .brk_i(brk), .op_valid_i(opv),
    .op_sel_i(opsel), .pc_i(pc), .sr_i(sr), .sp_i(sp), .acc_i(acc),
    .ready_o(ready), .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done),
    .pc_o(pc_out), .pc_we_o(pc_we), .sr_o(sr_out), .sr_we_o(sr_we),
    .sp_o(sp_out), .acc_o(acc_out), .acc_we_o(acc_we)
  );

  // memory model with access log
  logic [7:0]  stk [256];
  logic [15:0] wl_a [64];
  logic [7:0]  wl_d [64];
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  logic [15:0] rd_last = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) stk[i] <= 8'(i) ^ 8'h3C;
      mem_rdata <= '0;
    end else begin
      if (mem_we) begin
        wl_a[wr_cnt % 64] <= mem_addr;
        wl_d[wr_cnt % 64] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
        if (mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
      end
      if (mem_re) begin
        rd_cnt  <= rd_cnt + 1;
        rd_last <= mem_addr;
        if (mem_addr[15:8] == 8'h01)  mem_rdata <= stk[mem_addr[7:0]];
        else if (mem_addr == 16'hFFFE) mem_rdata <= VLO;
        else if (mem_addr == 16'hFFFF) mem_rdata <= VHI;
        else                           mem_rdata <= 8'h00;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // present a request for one accepting edge, return latency to done
  task automatic issue(input logic i_irq, input logic i_brk, input logic i_opv,
                       input logic [1:0] i_op, input logic [15:0] i_pc,
                       input logic [7:0] i_sr, input logic [7:0] i_sp,
                       input logic [7:0] i_acc, output int lat);
    @(negedge clk);
    irq = i_irq; brk = i_brk; opv = i_opv; opsel = i_op;
    pc = i_pc; sr = i_sr; sp = i_sp; acc = i_acc;
    @(posedge clk);
    @(negedge clk);
    irq = 1'b0; brk = 1'b0; opv = 1'b0;
    lat = 1;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_entry(input string tag, input logic [15:0] ret,
                             input logic [7:0] s_sr, input logic [7:0] s_sp,
                             input int wb, input int lat);
    chk(lat == 7, {tag, " R5 latency"}, lat, 7);
    chk(wr_cnt - wb == 3, {tag, " R3 write count"}, wr_cnt - wb, 3);
    chk(wl_a[wb % 64] == {8'h01, s_sp}, {tag, " R3 hi addr"}, wl_a[wb % 64], {8'h01, s_sp});
    chk(wl_d[wb % 64] == ret[15:8], {tag, " R6 hi byte"}, wl_d[wb % 64], ret[15:8]);
    chk(wl_a[(wb+1) % 64] == {8'h01, 8'(s_sp - 8'd1)}, {tag, " R9 lo addr"},
        wl_a[(wb+1) % 64], {8'h01, 8'(s_sp - 8'd1)});
    chk(wl_d[(wb+1) % 64] == ret[7:0], {tag, " R3 lo byte"}, wl_d[(wb+1) % 64], ret[7:0]);
    chk(wl_a[(wb+2) % 64] == {8'h01, 8'(s_sp - 8'd2)}, {tag, " R9 sr addr"},
        wl_a[(wb+2) % 64], {8'h01, 8'(s_sp - 8'd2)});
    chk(wl_d[(wb+2) % 64] == (s_sr | 8'h10), {tag, " R4 pushed status"},
        wl_d[(wb+2) % 64], s_sr | 8'h10);
    chk(rd_last == 16'hFFFF, {tag, " R5 last read"}, rd_last, 16'hFFFF);
    chk(pc_out == {VHI, VLO} && pc_we, {tag, " R5 vector"}, pc_out, {VHI, VLO});
    chk(sr_out == (s_sr | 8'h14) && sr_we, {tag, " R4 final status"}, sr_out, s_sr | 8'h14);
    chk(sp_out == 8'(s_sp - 8'd3), {tag, " R3 sp"}, sp_out, 8'(s_sp - 8'd3));
    @(negedge clk);
    chk(!done && ready, {tag, " R5 one-cycle done"}, done, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int lat, wb, rb;
    logic [7:0] ev;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 reset ready", ready, 1);
    chk(!done && !pc_we && !sr_we && !acc_we, "R1 reset strobes", done, 0);
    chk(!mem_we && !mem_re, "R1 reset bus quiet", mem_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      wb = wr_cnt;
      rb = rd_cnt;
      if (v.kind != 2'd2) begin
        issue(v.kind == 2'd0, v.kind == 2'd1, 1'b0, 2'b00, v.pc, v.sr, v.sp, v.acc, lat);
        check_entry($sformatf("vec%0d", k), (v.kind == 2'd1) ? v.pc + 16'd1 : v.pc,
                    v.sr, v.sp, wb, lat);
      end else if (!v.op[1]) begin
        issue(1'b0, 1'b0, 1'b1, v.op, v.pc, v.sr, v.sp, v.acc, lat);
        chk(lat == 2, $sformatf("vec%0d R7 push latency", k), lat, 2);
        chk(wr_cnt - wb == 1, $sformatf("vec%0d R7 write count", k), wr_cnt - wb, 1);
        chk(wl_a[wb % 64] == {8'h01, v.sp}, $sformatf("vec%0d R7 addr", k),
            wl_a[wb % 64], {8'h01, v.sp});
        ev = v.op[0] ? v.sr : v.acc;
        chk(wl_d[wb % 64] == ev, $sformatf("vec%0d R7 data", k), wl_d[wb % 64], ev);
        chk(sp_out == 8'(v.sp - 8'd1), $sformatf("vec%0d R9 push sp", k), sp_out, 8'(v.sp - 8'd1));
        chk(!pc_we && !sr_we && !acc_we, $sformatf("vec%0d R7 no loads", k), pc_we, 0);
      end else begin
        ev = stk[8'(v.sp + 8'd1)];
        issue(1'b0, 1'b0, 1'b1, v.op, v.pc, v.sr, v.sp, v.acc, lat);
        chk(lat == 3, $sformatf("vec%0d R8 pull latency", k), lat, 3);
        chk(rd_cnt - rb == 1 && rd_last == {8'h01, 8'(v.sp + 8'd1)},
            $sformatf("vec%0d R8 read addr", k), rd_last, {8'h01, 8'(v.sp + 8'd1)});
        chk(sp_out == 8'(v.sp + 8'd1), $sformatf("vec%0d R9 pull sp", k), sp_out, 8'(v.sp + 8'd1));
        if (v.op[0])
          chk(sr_we && !acc_we && sr_out == ev, $sformatf("vec%0d R8 status pull", k), sr_out, ev);
        else
          chk(acc_we && !sr_we && acc_out == ev, $sformatf("vec%0d R8 acc pull", k), acc_out, ev);
        chk(wr_cnt == wb, $sformatf("vec%0d R8 no write", k), wr_cnt - wb, 0);
      end
      @(negedge clk);
    end

    // R2: masked hardware request and R6: masked break
    for (int m = 0; m < 2; m++) begin
      logic seen;
      wb = wr_cnt; rb = rd_cnt; seen = 1'b0;
      @(negedge clk);
      irq = (m == 0); brk = (m == 1); sr = 8'h04; pc = 16'h4000; sp = 8'hF0;
      @(negedge clk);
      irq = 1'b0; brk = 1'b0;
      for (int c = 0; c < 8; c++) begin
        if (done || !ready) seen = 1'b1;
        @(negedge clk);
      end
      chk(!seen, m == 0 ? "R2 masked irq no action" : "R6 masked brk no action", seen, 0);
      chk(wr_cnt == wb && rd_cnt == rb, m == 0 ? "R2 masked irq bus quiet" : "R6 masked brk bus quiet",
          wr_cnt - wb, 0);
    end

    // R10: all three at once, hardware wins, return = pc
    wb = wr_cnt;
    issue(1'b1, 1'b1, 1'b1, 2'b00, 16'h0F0F, 8'h00, 8'hC0, 8'h77, lat);
    check_entry("R10 irq+brk+op", 16'h0F0F, 8'h00, 8'hC0, wb, lat);

    // R10: break beats stack op, return = pc+1
    wb = wr_cnt;
    issue(1'b0, 1'b1, 1'b1, 2'b10, 16'h3000, 8'h01, 8'h90, 8'h77, lat);
    check_entry("R10 brk+op", 16'h3001, 8'h01, 8'h90, wb, lat);

    // R10/R2: masked hardware request loses to stack op
    wb = wr_cnt;
    issue(1'b1, 1'b0, 1'b1, 2'b00, 16'h0000, 8'h04, 8'h50, 8'h99, lat);
    chk(lat == 2 && wr_cnt - wb == 1, "R10 masked irq yields to push", wr_cnt - wb, 1);
    chk(wl_d[wb % 64] == 8'h99, "R10 push data", wl_d[wb % 64], 8'h99);

    // R11: request during busy ignored
    wb = wr_cnt;
    @(negedge clk);
    opv = 1'b1; opsel = 2'b00; sp = 8'h20; acc = 8'h66; sr = 8'h00; pc = 16'h5555;
    @(negedge clk);
    opv = 1'b0; irq = 1'b1; brk = 1'b1;
    chk(!ready, "R11 busy after accept", ready, 0);
    @(negedge clk);
    irq = 1'b0; brk = 1'b0;
    chk(done == 1'b1, "R11 push done", done, 1);
    repeat (6) @(negedge clk);
    chk(wr_cnt - wb == 1, "R11 busy request dropped", wr_cnt - wb, 1);
    chk(ready == 1'b1, "R11 back to idle", ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule